// File: doc/BRIEF.md
# FIFO Status and Interrupt Controller

This block keeps the occupancy of a serial controller's receive and transmit byte FIFOs. It turns that occupancy into status flags, a single level-sensitive interrupt and one DMA request per direction. The FIFO memories and the shifting engine sit outside it. The block sees their push and pop strobes and the engine's transfer-done pulse, and it keeps its own occupancy count for each FIFO. It drives a flush strobe back to each FIFO.

Software reaches the block through a small register port with four words, selected by `reg_addr`:
- 0: interrupt enable.
- 1: status, write-1-to-clear.
- 2: FIFO control, holding the watermarks, the DMA enables and the flush bits.
- 3: read-only level word, holding both counts.

Writes take effect at the clock edge. Read data is a combinational view of the registered state.

Each status flag is set at the edge where its condition holds, judged on the count the FIFO has after that edge. A write of ones clears a flag. If the same flag's condition holds in that cycle, the set wins. Overflow and underflow record a push or pop that was refused.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset:
  - Both counts, the status word and the enable word are zero.
  - The interrupt, both DMA requests and both flush strobes are low.
  - Control reads 0x00200020: both watermarks 32, both DMA enables off.
- R2: Push and pop strobes change the counts.
  - An accepted push adds one and an accepted pop subtracts one. An accepted push and pop on the same FIFO in the same cycle leave the count unchanged.
  - The counts read from word 3: receive in bits 7:0, transmit in bits 23:16.
  - A count is visible right after the edge that takes the strobe.
- R3: Ready flags use the count after the edge and the watermark before it.
  - Receive ready (status bit 0) is set when the receive count is at least the receive watermark (control bits 7:0).
  - Transmit ready (status bit 4) is set when the transmit count is at most the transmit watermark (control bits 23:16).
- R4: Empty flags and full flags.
  - Receive empty is bit 1 and transmit empty is bit 5. Each is set when its count is 0.
  - Receive full is bit 2 and transmit full is bit 6. Each is set when its count equals DEPTH (64).
- R5: Writing the status word (word 1) clears the bits written as 1 and leaves the bits written as 0 unchanged. A flag whose set condition holds in the same cycle stays set.
- R6: A push to a full FIFO is refused.
  - The count does not change.
  - The overflow flag is set: bit 8 for receive, bit 10 for transmit.
  - A pop in the same cycle is still accepted.
- R7: A pop from an empty FIFO is refused.
  - The count does not change.
  - The underflow flag is set: bit 9 for receive, bit 11 for transmit.
  - A push in the same cycle is still accepted.
- R8: The enable word (word 0) stores only bits 0-2, 4-6 and 8-13 (mask 0x3F77). All other bits read 0.
- R9: `irq` is high exactly when some status bit and the enable bit at the same position are both 1.
- R10: Each DMA request follows its ready condition, gated by its enable.
  - `rx_dma_req` equals control bit 8 AND (receive count at least the receive watermark).
  - `tx_dma_req` equals control bit 24 AND (transmit count at most the transmit watermark).
  - Both use the current count and control values.
- R11: Writing 1 to control bit 15 (receive) or bit 31 (transmit) flushes that FIFO.
  - The flush bit and the matching flush output are high for one cycle.
  - At the next edge the count becomes 0. A push or pop in that cycle is ignored and raises no error flag.
  - The flush bit then returns to 0 unless it is written again.
- R12: A `xfer_done` pulse sets status bit 12. Status bits 3, 7 and 13-15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Byte written into the receive FIFO |
| rx_pop | input | 1 | Byte read from the receive FIFO |
| tx_push | input | 1 | Byte written into the transmit FIFO |
| tx_pop | input | 1 | Byte taken from the transmit FIFO |
| xfer_done | input | 1 | Transfer-complete pulse from the serial engine |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Level interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_flush | output | 1 | Receive FIFO flush strobe |
| tx_flush | output | 1 | Transmit FIFO flush strobe |

## Verification
Every strobe or register write is applied for one cycle. Counts, status flags, stored control and stored enables are all due at the first edge after it. `irq`, both DMA requests, the flush outputs and `reg_rdata` follow combinationally from those registers. A flush is the one two-step result: the strobe is visible after the writing edge, and the emptied count only after the following edge. The bench therefore drives each stimulus at a falling edge and lets one rising edge pass. It then deasserts the inputs and reads every word and every output before the next rising edge. For a flush it checks both consecutive cycles.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int REG_W   = 32;
    localparam int FLAG_W  = 16;
    localparam int FIELD_W = 8;
    localparam int NUM_DIR = 2;
    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;

    // Word select on the register port.
    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_LEVEL  = 2'd3
    } reg_sel_e;

    // Status layout: per direction, the level flags sit at 4*d and the
    // error flags at 8+2*d.
    localparam int LVL_STRIDE = 4;
    localparam int OFS_READY  = 0;
    localparam int OFS_EMPTY  = 1;
    localparam int OFS_FULL   = 2;
    localparam int ERR_BASE   = 8;
    localparam int OFS_OVF    = 0;
    localparam int OFS_UDF    = 1;
    localparam int BIT_DONE   = 12;

    localparam logic [FLAG_W-1:0] STATUS_IMPL = 16'h1F77;
    localparam logic [FLAG_W-1:0] ENABLE_IMPL = 16'h3F77;

    // Control word: one half per direction.
    localparam int CTRL_STRIDE = 16;
    localparam int CTRL_WM     = 0;
    localparam int CTRL_DMA    = 8;
    localparam int CTRL_FLUSH  = 15;

    typedef struct packed {
        logic [FIELD_W-1:0] wm;
        logic               dma_en;
        logic               flush;
    } dir_ctrl_t;

endpackage

// File: rtl/fifo_irq_occ.sv
module fifo_irq_occ #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             ovf_evt,
    output logic             udf_evt
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } occ_t;

    occ_t occ_d, occ_q;
    logic is_full, is_empty, take_push, take_pop;

    always_comb begin
        is_full   = (occ_q.cnt == FULL_CNT);
        is_empty  = (occ_q.cnt == '0);
        take_push = push && !is_full  && !flush;
        take_pop  = pop  && !is_empty && !flush;
        ovf_evt   = push && is_full  && !flush;
        udf_evt   = pop  && is_empty && !flush;

        occ_d = occ_q;
        if (flush) begin
            occ_d.cnt = '0;
        end else begin
            case ({take_push, take_pop})
                2'b10:   occ_d.cnt = occ_q.cnt + ONE;
                2'b01:   occ_d.cnt = occ_q.cnt - ONE;
                default: occ_d.cnt = occ_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign cnt_q  = occ_q.cnt;
    assign cnt_nx = occ_d.cnt;

endmodule

// File: rtl/fifo_irq_flags.sv
module fifo_irq_flags #(
    parameter int          W           = 16,
    parameter logic [15:0] STATUS_MASK = 16'h1F77,
    parameter logic [15:0] ENABLE_MASK = 16'h3F77
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         en_load,
    input  logic [W-1:0] en_data,
    output logic [W-1:0] status_q,
    output logic [W-1:0] enable_q,
    output logic         irq
);

    localparam logic [W-1:0] S_MASK = W'(STATUS_MASK);
    localparam logic [W-1:0] E_MASK = W'(ENABLE_MASK);

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] enable;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // Set beats clear in the same cycle.
        fl_d.status = ((fl_q.status & ~clr_vec) | set_vec) & S_MASK;
        if (en_load) fl_d.enable = en_data & E_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign status_q = fl_q.status;
    assign enable_q = fl_q.enable;
    assign irq      = |(fl_q.status & fl_q.enable);

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int RESET_WM = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_push,
    input  logic        rx_pop,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        xfer_done,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        rx_dma_req,
    output logic        tx_dma_req,
    output logic        rx_flush,
    output logic        tx_flush
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        dir_ctrl_t [NUM_DIR-1:0] dir;
    } ctrl_t;

    function automatic ctrl_t ctrl_reset();
        ctrl_t c;
        for (int d = 0; d < NUM_DIR; d++) begin
            c.dir[d].wm     = FIELD_W'(RESET_WM);
            c.dir[d].dma_en = 1'b0;
            c.dir[d].flush  = 1'b0;
        end
        return c;
    endfunction

    ctrl_t               ctrl_d, ctrl_q;
    reg_sel_e            sel;
    logic [NUM_DIR-1:0]  push_v, pop_v, flush_v, ovf_v, udf_v, ready_q_v;
    logic [CNT_W-1:0]    cnt_q_v  [NUM_DIR];
    logic [CNT_W-1:0]    cnt_nx_v [NUM_DIR];
    logic [FLAG_W-1:0]   set_vec, clr_vec, status_q, enable_q;
    logic                en_load;
    logic                unused_wbits;

    assign sel          = reg_sel_e'(reg_addr);
    assign push_v       = {tx_push, rx_push};
    assign pop_v        = {tx_pop, rx_pop};
    assign unused_wbits = ^reg_wdata;

    // One occupancy tracker per direction.
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        fifo_irq_occ #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_occ (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push_v[d]),
            .pop     (pop_v[d]),
            .flush   (flush_v[d]),
            .cnt_q   (cnt_q_v[d]),
            .cnt_nx  (cnt_nx_v[d]),
            .ovf_evt (ovf_v[d]),
            .udf_evt (udf_v[d])
        );
    end

    // Control word next state: flush bits last one cycle.
    always_comb begin
        ctrl_d = ctrl_q;
        for (int d = 0; d < NUM_DIR; d++) begin
            ctrl_d.dir[d].flush = 1'b0;
            if (reg_wr && sel == SEL_CTRL) begin
                ctrl_d.dir[d].wm     = reg_wdata[d*CTRL_STRIDE + CTRL_WM +: FIELD_W];
                ctrl_d.dir[d].dma_en = reg_wdata[d*CTRL_STRIDE + CTRL_DMA];
                ctrl_d.dir[d].flush  = reg_wdata[d*CTRL_STRIDE + CTRL_FLUSH];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= ctrl_reset();
        else        ctrl_q <= ctrl_d;
    end

    // Flag conditions per direction. The receive side is ready when full
    // enough, the transmit side when empty enough.
    always_comb begin
        logic [FIELD_W-1:0] lvl_nx;
        logic [FIELD_W-1:0] lvl_q;
        logic               rdy_nx;
        logic               rdy_q;

        set_vec = '0;
        for (int d = 0; d < NUM_DIR; d++) begin
            lvl_nx = FIELD_W'(cnt_nx_v[d]);
            lvl_q  = FIELD_W'(cnt_q_v[d]);
            if (d == DIR_RX) begin
                rdy_nx = (lvl_nx >= ctrl_q.dir[d].wm);
                rdy_q  = (lvl_q  >= ctrl_q.dir[d].wm);
            end else begin
                rdy_nx = (lvl_nx <= ctrl_q.dir[d].wm);
                rdy_q  = (lvl_q  <= ctrl_q.dir[d].wm);
            end
            set_vec[d*LVL_STRIDE + OFS_READY] = rdy_nx;
            set_vec[d*LVL_STRIDE + OFS_EMPTY] = (cnt_nx_v[d] == '0);
            set_vec[d*LVL_STRIDE + OFS_FULL]  = (cnt_nx_v[d] == CNT_W'(DEPTH));
            set_vec[ERR_BASE + 2*d + OFS_OVF] = ovf_v[d];
            set_vec[ERR_BASE + 2*d + OFS_UDF] = udf_v[d];
            ready_q_v[d] = rdy_q;
            flush_v[d]   = ctrl_q.dir[d].flush;
        end
        set_vec[BIT_DONE] = xfer_done;
        clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata[FLAG_W-1:0] : '0;
        en_load = reg_wr && sel == SEL_ENABLE;
    end

    fifo_irq_flags #(
        .W           (FLAG_W),
        .STATUS_MASK (STATUS_IMPL),
        .ENABLE_MASK (ENABLE_IMPL)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .en_load  (en_load),
        .en_data  (reg_wdata[FLAG_W-1:0]),
        .status_q (status_q),
        .enable_q (enable_q),
        .irq      (irq)
    );

    // Read view of the selected word.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_ENABLE: reg_rdata[FLAG_W-1:0] = enable_q;
            SEL_STATUS: reg_rdata[FLAG_W-1:0] = status_q;
            SEL_CTRL: begin
                for (int d = 0; d < NUM_DIR; d++) begin
                    reg_rdata[d*CTRL_STRIDE + CTRL_WM +: FIELD_W] = ctrl_q.dir[d].wm;
                    reg_rdata[d*CTRL_STRIDE + CTRL_DMA]           = ctrl_q.dir[d].dma_en;
                    reg_rdata[d*CTRL_STRIDE + CTRL_FLUSH]         = ctrl_q.dir[d].flush;
                end
            end
            SEL_LEVEL: begin
                for (int d = 0; d < NUM_DIR; d++) begin
                    reg_rdata[d*CTRL_STRIDE +: FIELD_W] = FIELD_W'(cnt_q_v[d]);
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    assign rx_dma_req = ready_q_v[DIR_RX] && ctrl_q.dir[DIR_RX].dma_en;
    assign tx_dma_req = ready_q_v[DIR_TX] && ctrl_q.dir[DIR_TX].dma_en;
    assign rx_flush   = ctrl_q.dir[DIR_RX].flush;
    assign tx_flush   = ctrl_q.dir[DIR_TX].flush;

endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             xfer_done,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             rx_flush,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [15:0]      status
);

    // R2: counts never exceed the depth
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CNT_W'(DEPTH)) && (tx_cnt <= CNT_W'(DEPTH)));

    // R2: without a flush the receive count moves by at most one
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_flush |=> (rx_cnt == $past(rx_cnt)) ||
                      (rx_cnt == $past(rx_cnt) + CNT_W'(1)) ||
                      (rx_cnt + CNT_W'(1) == $past(rx_cnt)));

    // R6: a refused push leaves the overflow flag set
    a_r6_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_cnt == CNT_W'(DEPTH) && !rx_flush) |=> status[8]);

    // R11: the flush strobe empties the FIFO at the next edge
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_cnt == '0));

    // R11: the flush bit lasts one cycle unless written again
    a_r11_flush_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !(reg_wr && reg_addr == 2'd2 && reg_wdata[15])) |=> !rx_flush);

    // R12: a transfer-done pulse is recorded
    a_r12_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> status[12]);

endmodule

bind fifo_irq_ctrl fifo_irq_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_push   (rx_push),
    .xfer_done (xfer_done),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_flush  (rx_flush),
    .rx_cnt    (cnt_q_v[0]),
    .tx_cnt    (cnt_q_v[1]),
    .status    (status_q)
);

// File: tb/fifo_irq_ctrl_bench.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_bench;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, xfer_done = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq, rx_dma_req, tx_dma_req, rx_flush, tx_flush;

    always #2.5 clk = ~clk;

    fifo_irq_ctrl #(.DEPTH(DEPTH), .RESET_WM(32)) u_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
        .xfer_done(xfer_done),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq(irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_flush(rx_flush), .tx_flush(tx_flush)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;
    bit all_done = 0;

    // Reference state derived from the requirements.
    int m_cnt [2];
    int m_wm  [2];
    bit m_dma [2];
    bit m_fl  [2];
    logic [15:0] m_status;
    logic [15:0] m_en;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] w = '0;
        for (int d = 0; d < 2; d++) begin
            w[16*d +: 8] = m_wm[d][7:0];
            w[16*d + 8]  = m_dma[d];
            w[16*d + 15] = m_fl[d];
        end
        return w;
    endfunction

    function automatic bit rdy(input int d);
        return (d == 0) ? (m_cnt[d] >= m_wm[d]) : (m_cnt[d] <= m_wm[d]);
    endfunction

    task automatic read_word(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    // One cycle of stimulus, reference update, then a full set of checks.
    task automatic cyc(input string tag, input bit rp, input bit rpo, input bit tp,
                       input bit tpo, input bit dn, input bit wr, input int addr,
                       input logic [31:0] wd);
        bit push [2];
        bit pop  [2];
        logic [15:0] setv;
        logic [15:0] clr;
        logic [31:0] v;
        @(negedge clk);
        rx_push = rp; rx_pop = rpo; tx_push = tp; tx_pop = tpo; xfer_done = dn;
        reg_wr = wr; reg_addr = addr[1:0]; reg_wdata = wd;
        push[0] = rp; push[1] = tp; pop[0] = rpo; pop[1] = tpo;
        setv = '0;
        for (int d = 0; d < 2; d++) begin
            if (m_fl[d]) begin
                m_cnt[d] = 0;
            end else begin
                bit full  = (m_cnt[d] == DEPTH);
                bit empty = (m_cnt[d] == 0);
                if (push[d] && full)  setv[8 + 2*d] = 1'b1;
                if (pop[d] && empty)  setv[9 + 2*d] = 1'b1;
                m_cnt[d] = m_cnt[d] + ((push[d] && !full) ? 1 : 0) - ((pop[d] && !empty) ? 1 : 0);
            end
            setv[4*d]     = rdy(d);
            setv[4*d + 1] = (m_cnt[d] == 0);
            setv[4*d + 2] = (m_cnt[d] == DEPTH);
        end
        setv[12] = dn;
        for (int d = 0; d < 2; d++) begin
            if (wr && addr == 2) begin
                m_wm[d]  = int'(wd[16*d +: 8]);
                m_dma[d] = wd[16*d + 8];
                m_fl[d]  = wd[16*d + 15];
            end else begin
                m_fl[d] = 1'b0;
            end
        end
        if (wr && addr == 0) m_en = wd[15:0] & 16'h3F77;
        clr = (wr && addr == 1) ? wd[15:0] : 16'h0;
        m_status = ((m_status & ~clr) | setv) & 16'h1F77;
        @(posedge clk);
        #1;
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; xfer_done = 0;
        reg_wr = 0; reg_wdata = 0;
        read_word(2'd1, v); check(tag, v, {16'h0, m_status});
        read_word(2'd3, v); check("R2 level", v, {8'h0, 8'(m_cnt[1]), 8'h0, 8'(m_cnt[0])});
        read_word(2'd2, v); check("R11 ctrl", v, exp_ctrl());
        read_word(2'd0, v); check("R8 enable", v, {16'h0, m_en});
        check("R9 irq", {31'h0, irq}, {31'h0, |(m_status & m_en)});
        check("R10 dma", {30'h0, tx_dma_req, rx_dma_req},
              {30'h0, rdy(1) && m_dma[1], rdy(0) && m_dma[0]});
        check("R11 flush", {30'h0, tx_flush, rx_flush}, {30'h0, m_fl[1], m_fl[0]});
    endtask

    task automatic step(input string tag, input bit rp, input bit rpo, input bit tp, input bit tpo);
        cyc(tag, rp, rpo, tp, tpo, 1'b0, 1'b1, 1, 32'h0000_FFFF);
    endtask

    task automatic set_ctrl(input string tag, input int rwm, input int twm,
                            input bit rdma, input bit tdma, input bit rfl, input bit tfl);
        logic [31:0] w;
        w = {tfl, 6'h0, tdma, 8'(twm), rfl, 6'h0, rdma, 8'(rwm)};
        cyc(tag, 0, 0, 0, 0, 0, 1'b1, 2, w);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000 && !all_done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got %0d cycles expected completion", n_cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int d = 0; d < 2; d++) begin
            m_cnt[d] = 0; m_wm[d] = 32; m_dma[d] = 0; m_fl[d] = 0;
        end
        m_status = '0;
        m_en = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state
        read_word(2'd1, v); check("R1 status", v, 32'h0);
        read_word(2'd0, v); check("R1 enable", v, 32'h0);
        read_word(2'd3, v); check("R1 level", v, 32'h0);
        read_word(2'd2, v); check("R1 ctrl", v, 32'h0020_0020);
        check("R1 outputs", {27'h0, irq, rx_dma_req, tx_dma_req, rx_flush, tx_flush}, 32'h0);

        // R8: only implemented enable bits are kept
        cyc("R8", 0, 0, 0, 0, 0, 1'b1, 0, 32'hFFFF_FFFF);
        cyc("R8", 0, 0, 0, 0, 0, 1'b1, 0, 32'h0000_1111);

        // R3 R4 R6: fill both FIFOs past full with rx wm 5, tx wm 3
        set_ctrl("R3", 5, 3, 1, 1, 0, 0);
        for (int i = 0; i <= DEPTH; i++) step((i == DEPTH) ? "R6" : "R3", 1, 0, 1, 0);

        // R5: zeros leave flags, ones clear, set condition wins
        cyc("R5", 0, 0, 0, 0, 0, 1'b1, 1, 32'h0);
        cyc("R5", 0, 0, 0, 0, 0, 1'b1, 1, 32'h0000_0500);
        cyc("R5", 0, 0, 0, 0, 0, 1'b1, 1, 32'h0000_0044);

        // R6: push and pop at full, the pop is still taken
        cyc("R6", 1, 1, 1, 1, 0, 1'b0, 0, 32'h0);

        // R7 R4: drain past empty
        for (int i = 0; i <= DEPTH; i++) step((i >= DEPTH - 1) ? "R7" : "R4", 0, 1, 0, 1);
        // R7: pop and push at empty, the push is still taken
        step("R7", 1, 1, 1, 1);
        step("R7", 0, 1, 0, 1);

        // R3 R10: watermark sweep, both directions, DMA gated on odd values
        for (int w = 0; w <= 9; w++) begin
            set_ctrl("R10", w, w, w[0], !w[0], 0, 0);
            for (int i = 0; i < 9; i++) step("R3", 1, 0, 1, 0);
            for (int i = 0; i < 9; i++) step("R3", 0, 1, 0, 1);
        end

        // R12: transfer done
        cyc("R12", 0, 0, 0, 0, 1'b1, 1'b0, 0, 32'h0);

        // R9: one enable bit at a time against the current flags
        for (int b = 0; b < 16; b++) cyc("R9", 0, 0, 0, 0, 0, 1'b1, 0, 32'h1 << b);
        cyc("R9", 0, 0, 0, 0, 0, 1'b1, 0, 32'h0000_3F77);

        // R11: receive flush with an ignored push, then transmit flush
        set_ctrl("R11", 4, 60, 1, 1, 0, 0);
        for (int i = 0; i < 6; i++) step("R11", 1, 0, 1, 0);
        set_ctrl("R11", 4, 60, 1, 1, 1, 0);
        cyc("R11", 1, 0, 0, 0, 0, 1'b0, 0, 32'h0);
        step("R11", 0, 1, 0, 0);
        set_ctrl("R11", 4, 60, 1, 1, 0, 1);
        cyc("R11", 0, 0, 1, 1, 0, 1'b0, 0, 32'h0);
        set_ctrl("R11", 4, 60, 0, 0, 1, 1);
        set_ctrl("R11", 4, 60, 0, 0, 1, 1);
        step("R11", 1, 1, 1, 1);
        step("R11", 0, 0, 0, 0);

        all_done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule